// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns a one-byte indexed addressing descriptor into a 16-bit operand address for an accumulator-based processor core. The descriptor picks a base register (X, Y, stack pointer or the address of the next instruction). It then picks how an offset is formed: a short signed constant inside the descriptor, a longer constant in the one or two bytes that follow it, or the contents of an accumulator. The descriptor can also ask for a small step to be applied to the base register before or after use, with the changed value written back.

The two indirect forms treat base plus offset as the location of a 16-bit pointer. The block reads that pointer one byte at a time over a simple request/acknowledge memory port, and the pointer becomes the operand address. The core pulses `start` with the descriptor and operands valid. It takes the results when `done` pulses. It also uses `extCount` to learn how many bytes after the descriptor were consumed.

Top module: `idx_ea_gen`

## Requirements
- R1: Base select code 00 picks `regX`, 01 picks `regY`, 10 picks `regSp` and 11 picks `regPc` (the next-instruction address). The code sits in descriptor bits [7:6], except in forms whose top three bits are 111, where it sits in bits [4:3].
- R2: Descriptor `bb0ooooo` adds the two's-complement value of bits [4:0] (-16..+15) to the base. `extCount` is 0.
- R3: Descriptor `111bb00s` adds a 9-bit signed offset whose sign is bit 0 and whose low eight bits are `extFirst` (-256..+255). `extCount` is 1.
- R4: Descriptor `111bb010` adds the 16-bit offset {`extFirst`,`extSecond`}, with `extFirst` the high byte. `extCount` is 2.
- R5: Descriptor `bb1tssss` with bb not 11 is step mode. Step field 0000..0111 means +1..+8 and 1111..1000 means -1..-8. With t=0 the address is the stepped base; with t=1 it is the original base. `extCount` is 0.
- R6: In step mode `wbEn` is 1, `wbSel` holds the base select code and `wbValue` holds the stepped base. In every other form `wbEn` is 0.
- R7: Descriptor `111bb1aa` adds accumulator A (aa=00) or B (aa=01), zero-extended, or D={A,B} (aa=10) to the base. `extCount` is 0.
- R8: Descriptors `111bb011` (16-bit offset, `extCount` 2) and `111bb111` (D offset, `extCount` 0) are indirect. Let P be base plus offset. The address is then {byte at P, byte at P+1}, so the high byte is at the lower address.
- R9: Each pointer byte read holds `memReq` high with `memAddr` steady until a cycle with `memAck` high. `memData` is taken in that cycle. No request is made while idle.
- R10: `done` is a single-cycle pulse. It comes in the cycle after `start` for direct forms and in the cycle after the second acknowledge for indirect forms. The results hold until the next accepted `start`.
- R11: A `start` while `busy` is high is ignored, and the running lookup finishes with its original operands.
- R12: All address sums, steps and the P+1 pointer address wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a lookup with the current inputs |
| postbyte | input | 8 | Addressing descriptor byte |
| extFirst | input | 8 | First byte after the descriptor |
| extSecond | input | 8 | Second byte after the descriptor |
| regX | input | 16 | Index register X |
| regY | input | 16 | Index register Y |
| regSp | input | 16 | Stack pointer |
| regPc | input | 16 | Address of the next instruction |
| accA | input | 8 | Accumulator A |
| accB | input | 8 | Accumulator B |
| memReq | output | 1 | Pointer byte read request |
| memAddr | output | 16 | Pointer byte address |
| memAck | input | 1 | Read data valid |
| memData | input | 8 | Read data byte |
| busy | output | 1 | A lookup is in progress |
| done | output | 1 | Results valid pulse |
| effAddr | output | 16 | Operand effective address |
| extCount | output | 2 | Bytes consumed after the descriptor |
| wbEn | output | 1 | Base register write-back enable |
| wbSel | output | 2 | Register to write back (select code) |
| wbValue | output | 16 | Value to write back |

## Verification
The hardest case to reach is an indirect lookup where the memory stalls and a second `start` arrives with different operands mid-fetch. The pointer location sits at FFFF, so the second byte address must wrap. The bench responder inserts a chosen number of wait cycles before each acknowledge. One run pulses `start` with a changed descriptor while the first pointer byte is pending. Another uses a Y base of FFFF with a zero offset. The pointer bytes come from an address hash, so a wrong or unwrapped fetch address shows up as a wrong operand address.

// File: rtl/idx_ea_pkg.sv
`timescale 1ns/1ps
package idx_ea_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadDecode;
    logic capHi;
    logic capLo;
    logic selLo;
  } ctrlStrobes_t;
endpackage

// File: rtl/idx_ea_datapath.sv
`timescale 1ns/1ps
module idx_ea_datapath
  import idx_ea_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [BYTE_W-1:0]   postbyte,
  input  logic [BYTE_W-1:0]   extFirst,
  input  logic [BYTE_W-1:0]   extSecond,
  input  logic [ADDR_W-1:0]   regX,
  input  logic [ADDR_W-1:0]   regY,
  input  logic [ADDR_W-1:0]   regSp,
  input  logic [ADDR_W-1:0]   regPc,
  input  logic [BYTE_W-1:0]   accA,
  input  logic [BYTE_W-1:0]   accB,
  input  logic [BYTE_W-1:0]   memData,
  output logic                decIndirect,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [CNT_W-1:0]    extCount,
  output logic                wbEn,
  output logic [SEL_W-1:0]    wbSel,
  output logic [ADDR_W-1:0]   wbValue
);
  localparam int SHORT_W = 5;
  localparam int STEP_W  = 4;

  logic [SEL_W-1:0]  baseSel;
  logic [ADDR_W-1:0] baseVal, offVal, stepVal, stepped;
  logic [ADDR_W-1:0] decEa;
  logic [CNT_W-1:0]  decCnt;
  logic              decWb;
  logic              isShort, isStep;

  logic [ADDR_W-1:0] eaReg, wbValReg;
  logic [CNT_W-1:0]  cntReg;
  logic [SEL_W-1:0]  wbSelReg;
  logic              wbEnReg;
  logic [BYTE_W-1:0] ptrHi;

  assign isShort = ~postbyte[5];
  assign isStep  = postbyte[5] & (postbyte[7:5] != 3'b111);
  assign baseSel = (isShort | isStep) ? postbyte[7:6] : postbyte[4:3];

  always_comb begin
    unique case (baseSel)
      2'b00:   baseVal = regX;
      2'b01:   baseVal = regY;
      2'b10:   baseVal = regSp;
      default: baseVal = regPc;
    endcase
  end

  // step field: non-negative codes mean +1..+8, negative ones -1..-8
  assign stepVal = postbyte[3]
                 ? {{(ADDR_W-STEP_W){1'b1}}, postbyte[STEP_W-1:0]}
                 : {{(ADDR_W-STEP_W){1'b0}}, postbyte[STEP_W-1:0]} + 1'b1;
  assign stepped = baseVal + stepVal;

  always_comb begin
    offVal      = '0;
    decCnt      = '0;
    decWb       = 1'b0;
    decIndirect = 1'b0;
    if (isShort) begin
      offVal = {{(ADDR_W-SHORT_W){postbyte[4]}}, postbyte[SHORT_W-1:0]};
    end else if (isStep) begin
      decWb = 1'b1;
    end else if (!postbyte[2]) begin
      if (!postbyte[1]) begin
        offVal = {{(ADDR_W-BYTE_W){postbyte[0]}}, extFirst};
        decCnt = 2'd1;
      end else begin
        offVal      = {extFirst, extSecond};
        decCnt      = 2'd2;
        decIndirect = postbyte[0];
      end
    end else begin
      unique case (postbyte[1:0])
        2'b00:   offVal = {{(ADDR_W-BYTE_W){1'b0}}, accA};
        2'b01:   offVal = {{(ADDR_W-BYTE_W){1'b0}}, accB};
        default: offVal = {accA, accB};
      endcase
      decIndirect = (postbyte[1:0] == 2'b11);
    end
  end

  assign decEa = isStep ? (postbyte[4] ? baseVal : stepped) : (baseVal + offVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaReg    <= '0;
      cntReg   <= '0;
      wbEnReg  <= 1'b0;
      wbSelReg <= '0;
      wbValReg <= '0;
      ptrHi    <= '0;
    end else begin
      if (strb.loadDecode) begin
        eaReg    <= decEa;
        cntReg   <= decCnt;
        wbEnReg  <= decWb;
        wbSelReg <= baseSel;
        wbValReg <= stepped;
      end
      if (strb.capHi) ptrHi <= memData;
      if (strb.capLo) eaReg <= {ptrHi, memData};
    end
  end

  assign memAddr  = strb.selLo ? eaReg + 1'b1 : eaReg;
  assign effAddr  = eaReg;
  assign extCount = cntReg;
  assign wbEn     = wbEnReg;
  assign wbSel    = wbSelReg;
  assign wbValue  = wbValReg;

  AST_WB_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    wbEnReg |-> (wbSelReg != 2'b11)); // R6
  AST_WB_NO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    wbEnReg |-> (cntReg == 2'd0)); // R5
endmodule

// File: rtl/idx_ea_control.sv
`timescale 1ns/1ps
module idx_ea_control
  import idx_ea_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         decIndirect,
  input  logic         memAck,
  output ctrlStrobes_t strb,
  output logic         memReq,
  output logic         busy,
  output logic         done
);
  phase_t phase, phaseNext;
  logic   doneNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    doneNext  = 1'b0;
    memReq    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          strb.loadDecode = 1'b1;
          if (decIndirect) phaseNext = PH_HI;
          else             doneNext  = 1'b1;
        end
      end
      PH_HI: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.capHi = 1'b1;
          phaseNext  = PH_LO;
        end
      end
      default: begin
        memReq     = 1'b1;
        strb.selLo = 1'b1;
        if (memAck) begin
          strb.capLo = 1'b1;
          doneNext   = 1'b1;
          phaseNext  = PH_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= doneNext;
    end
  end

  assign busy = (phase != PH_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !memAck) |=> busy); // R11
endmodule

// File: rtl/idx_ea_gen.sv
`timescale 1ns/1ps
module idx_ea_gen
  import idx_ea_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  postbyte,
  input  logic [7:0]  extFirst,
  input  logic [7:0]  extSecond,
  input  logic [15:0] regX,
  input  logic [15:0] regY,
  input  logic [15:0] regSp,
  input  logic [15:0] regPc,
  input  logic [7:0]  accA,
  input  logic [7:0]  accB,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic        memAck,
  input  logic [7:0]  memData,
  output logic        busy,
  output logic        done,
  output logic [15:0] effAddr,
  output logic [1:0]  extCount,
  output logic        wbEn,
  output logic [1:0]  wbSel,
  output logic [15:0] wbValue
);
  ctrlStrobes_t strb;
  logic         decIndirect;

  idx_ea_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .decIndirect(decIndirect),
    .memAck(memAck), .strb(strb), .memReq(memReq), .busy(busy), .done(done)
  );

  idx_ea_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .postbyte(postbyte),
    .extFirst(extFirst), .extSecond(extSecond), .regX(regX), .regY(regY),
    .regSp(regSp), .regPc(regPc), .accA(accA), .accB(accB),
    .memData(memData), .decIndirect(decIndirect), .memAddr(memAddr),
    .effAddr(effAddr), .extCount(extCount), .wbEn(wbEn), .wbSel(wbSel),
    .wbValue(wbValue)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R9
  AST_PTR_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (!memReq || (memAddr == $past(memAddr) + 16'd1))); // R8
endmodule

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0, extFirst = '0, extSecond = '0, accA = '0, accB = '0;
  logic [15:0] regX = '0, regY = '0, regSp = '0, regPc = '0;
  logic        memReq, memAck = 1'b0;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic        busy, done, wbEn;
  logic [15:0] effAddr, wbValue;
  logic [1:0]  extCount, wbSel;

  int checks = 0;
  int fails  = 0;
  int respLat = 0;
  int respCnt = 0;

  always #2.5 clk = ~clk;

  idx_ea_gen u0 (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // responder: acknowledges after respLat wait cycles per byte
  always @(negedge clk) begin
    if (memReq) begin
      if (respCnt == respLat) begin
        memAck  <= 1'b1;
        memData <= memByte(memAddr);
        respCnt <= 0;
      end else begin
        memAck  <= 1'b0;
        respCnt <= respCnt + 1;
      end
    end else begin
      memAck  <= 1'b0;
      respCnt <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference built on integers
  task automatic refModel(input logic [7:0] pb, output int ea, output int cnt,
                          output bit wb, output int sel, output int wbv, output bit ind);
    int base, off, n, st, p;
    sel = (pb[7:5] == 3'b111) ? int'(pb[4:3]) : int'(pb[7:6]);
    base = (sel == 0) ? int'(regX) : (sel == 1) ? int'(regY) : (sel == 2) ? int'(regSp) : int'(regPc);
    cnt = 0; wb = 0; wbv = 0; ind = 0; off = 0;
    if (pb[5] == 1'b0) begin
      n = int'(pb[4:0]);
      off = (n > 15) ? n - 32 : n;
      ea = (base + off) & 16'hFFFF;
    end else if (pb[7:5] != 3'b111) begin
      n = int'(pb[3:0]);
      st = (n < 8) ? n + 1 : n - 16;
      wbv = (base + st) & 16'hFFFF;
      wb = 1;
      ea = pb[4] ? base : wbv;
    end else begin
      if (pb[2:1] == 2'b00) begin off = pb[0] ? int'(extFirst) - 256 : int'(extFirst); cnt = 1; end
      else if (pb[2:1] == 2'b01) begin off = int'(extFirst) * 256 + int'(extSecond); cnt = 2; ind = pb[0]; end
      else if (pb[1:0] == 2'b00) off = int'(accA);
      else if (pb[1:0] == 2'b01) off = int'(accB);
      else begin off = int'(accA) * 256 + int'(accB); ind = (pb[1:0] == 2'b11); end
      ea = (base + off) & 16'hFFFF;
      if (ind) begin
        p = ea;
        ea = int'(memByte(p[15:0])) * 256 + int'(memByte(16'(p + 1)));
      end
    end
  endtask

  task automatic runVec(input logic [7:0] pb, input logic [7:0] e0, input logic [7:0] e1,
                        input int lat, input bit poke, input string req);
    int ea, cnt, sel, wbv, due;
    bit wb, ind;
    @(negedge clk);
    postbyte = pb; extFirst = e0; extSecond = e1; respLat = lat;
    refModel(pb, ea, cnt, wb, sel, wbv, ind);
    due = ind ? 2 * (lat + 1) : 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= due; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 1) begin start = 1'b1; postbyte = 8'h1F; regX = regX ^ 16'h5555; end
      if (poke && k == 2) start = 1'b0;
      check(done == (k == due), {req, " done timing"}, int'(done), int'(k == due));
      if (k == due) begin
        check(int'(effAddr) == ea, {req, " effAddr"}, int'(effAddr), ea);
        check(int'(extCount) == cnt, {req, " extCount"}, int'(extCount), cnt);
        check(wbEn == wb, {req, " R6 wbEn"}, int'(wbEn), int'(wb));
        if (wb) begin
          check(int'(wbSel) == sel, {req, " R6 wbSel"}, int'(wbSel), sel);
          check(int'(wbValue) == wbv, {req, " R6 wbValue"}, int'(wbValue), wbv);
        end
      end
    end
    @(negedge clk);
    check(!done && !busy, {req, " R10 settles"}, int'({done, busy}), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !busy && !memReq && effAddr == 16'h0, "R10 reset state", int'(effAddr), 0);
    rstN = 1'b1;
    regX = 16'h1000; regY = 16'h2000; regSp = 16'h3C00; regPc = 16'h4002;
    accA = 8'h80; accB = 8'h7F;
    // R1 R2: short constant offset over every base
    runVec(8'b00001111, 8'h00, 8'h00, 0, 0, "R2 X+15");
    runVec(8'b01010000, 8'h00, 8'h00, 0, 0, "R2 Y-16");
    runVec(8'b10011111, 8'h00, 8'h00, 0, 0, "R1 SP-1");
    runVec(8'b11000101, 8'h00, 8'h00, 0, 0, "R1 PC+5");
    // R3: nine-bit offsets
    runVec(8'b11100000, 8'hFF, 8'h00, 0, 0, "R3 X+255");
    runVec(8'b11101001, 8'h00, 8'h00, 0, 0, "R3 Y-256");
    runVec(8'b11110001, 8'hEC, 8'h00, 0, 0, "R3 SP-20");
    // R4 R12: sixteen-bit offsets, one wrapping past FFFF
    runVec(8'b11100010, 8'h12, 8'h34, 0, 0, "R4 X+1234");
    runVec(8'b11111010, 8'hFF, 8'hFE, 0, 0, "R4 R12 PC wrap");
    // R5 R6: step forms
    runVec(8'b00100000, 8'h00, 8'h00, 0, 0, "R5 X pre+1");
    runVec(8'b01111000, 8'h00, 8'h00, 0, 0, "R5 Y post-8");
    runVec(8'b10100111, 8'h00, 8'h00, 0, 0, "R5 SP pre+8");
    runVec(8'b00111111, 8'h00, 8'h00, 0, 0, "R5 X post-1");
    regX = 16'hFFFF;
    runVec(8'b00100000, 8'h00, 8'h00, 0, 0, "R12 X pre+1 wrap");
    regX = 16'h1000;
    // R7: accumulator offsets, A is zero-extended
    runVec(8'b11100100, 8'h00, 8'h00, 0, 0, "R7 A,X");
    runVec(8'b11101101, 8'h00, 8'h00, 0, 0, "R7 B,Y");
    runVec(8'b11110110, 8'h00, 8'h00, 0, 0, "R7 D,SP");
    // R8 R9: indirect forms with differing memory latency
    runVec(8'b11100011, 8'h00, 8'h10, 0, 0, "R8 [16,X] lat0");
    runVec(8'b11111111, 8'h00, 8'h00, 2, 0, "R8 R9 [D,PC] lat2");
    regY = 16'hFFFF;
    runVec(8'b11101011, 8'h00, 8'h00, 1, 0, "R12 [0,Y] pointer wrap");
    // R11: a second start mid-fetch is ignored
    runVec(8'b11100011, 8'h01, 8'h00, 3, 1, "R11 start while busy");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule